// File: doc/BRIEF.md
# Layered Tick Start and Completion Sequencer

This block paces a network of compute cores grouped into layers, one tick at a time. A tick request from outside is turned into one internal start pulse, which goes to every core in the same cycle, but only when no tick is in flight. A request that arrives while a tick is running is remembered and started as soon as the network goes idle. Any further requests during that time fold into the same single follow-up tick.

Cores report completion with done pulses that may arrive on different cycles. Each layer remembers which of its cores have reported. When the last core of a layer reports, the layer gives a single-cycle completion pulse. A second stage merges the layer pulses in the same way and gives one single-cycle network completion pulse. That pulse ends the busy period.

Top module: `tickSequencer`

## Requirements
- R1: While reset is active, and in the first cycle after it, tickStart, busy, every layerDone bit and netDone are low.
- R2: When tickReq is high in a cycle in which busy is low, tickStart is high for exactly one cycle, namely the next cycle.
- R3: A tickReq seen while busy is high is held. tickStart then rises two cycles after the netDone pulse of the running tick (busy is low for the one cycle between).
- R4: Any number of requests made during one busy period produce exactly one follow-up tick. No further tickStart comes after that follow-up tick.
- R5: For layer l, layerDone[l] is high for one cycle. That cycle is the one after the cycle in which the last core of layer l has given its first done pulse since tickStart.
- R6: netDone is high for one cycle. That cycle is the one after the cycle in which the last layerDone bit fired for the current tick, so it comes two cycles after the last core's done.
- R7: A core done input held high for many cycles counts once. layerDone and netDone still fire only once per tick.
- R8: Core done inputs are ignored while busy is low and in the tickStart cycle itself. Done pulses given at those times do not count toward the tick.
- R9: busy rises in the same cycle as tickStart. It stays high through the netDone cycle and falls in the cycle after it.
- R10: coreDone bit l*CORES_PER_LAYER+c belongs to core c of layer l. layerDone bit l reports layer l.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickReq | input | 1 | Request for a new tick |
| coreDone | input | NUM_LAYERS*CORES_PER_LAYER | Done pulse per core, grouped by layer |
| tickStart | output | 1 | One-cycle start pulse broadcast to all cores |
| busy | output | 1 | High while a tick is in flight |
| layerDone | output | NUM_LAYERS | One-cycle completion pulse per layer |
| netDone | output | 1 | One-cycle completion pulse for the whole network |

## Verification
tickStart is due one cycle after an idle request, and two cycles after netDone for a held request. layerDone is due one cycle after the last done of its layer, netDone two cycles after the last core overall, and busy falls one cycle after netDone. The bench draws a random done delay for each core. From these delays it computes the exact cycle of every pulse, then compares all outputs in every cycle of the tick, shortly after the rising edge. Stale done pulses, held done levels and requests made while busy are placed at fixed cycles of that same count, so their expected effect (or absence of effect) is known in advance.

// File: rtl/tickSeqPkg.sv
package tickSeqPkg;
  // Strobes from the control FSM into the completion datapath.
  typedef struct packed {
    logic clearLatches;  // wipe all done memory (start cycle)
    logic acceptDone;    // done pulses may be recorded
  } seqStrobe_t;
endpackage

// File: rtl/tickCtrl.sv
module tickCtrl
  import tickSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickReq,
  input  logic       netDone,
  output logic       tickStart,
  output logic       busy,
  output seqStrobe_t strobe
);
  logic pending;
  logic issue;

  assign issue = !busy && (tickReq || pending);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickStart <= 1'b0;
      busy      <= 1'b0;
      pending   <= 1'b0;
    end else begin
      tickStart <= issue;
      if (issue)        busy <= 1'b1;
      else if (netDone) busy <= 1'b0;
      if (issue)        pending <= 1'b0;
      else if (tickReq) pending <= 1'b1;
    end
  end

  always_comb begin
    strobe.clearLatches = tickStart;
    strobe.acceptDone   = busy && !tickStart;
  end
endmodule

// File: rtl/doneMerge.sv
module doneMerge #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             accept,
  input  logic [WIDTH-1:0] pulses,
  output logic             done
);
  logic [WIDTH-1:0] seen;
  logic             fired;
  logic             allNow;

  assign allNow = &(seen | (pulses & {WIDTH{accept}}));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seen  <= '0;
      fired <= 1'b0;
      done  <= 1'b0;
    end else if (clear) begin
      seen  <= '0;
      fired <= 1'b0;
      done  <= 1'b0;
    end else if (accept) begin
      seen <= seen | pulses;
      done <= allNow && !fired;
      if (allNow) fired <= 1'b1;
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/doneTree.sv
module doneTree
  import tickSeqPkg::*;
#(
  parameter int NUM_LAYERS      = 3,
  parameter int CORES_PER_LAYER = 4
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  seqStrobe_t                            strobe,
  input  logic [NUM_LAYERS*CORES_PER_LAYER-1:0] coreDone,
  output logic [NUM_LAYERS-1:0]                 layerDone,
  output logic                                  netDone
);
  for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
    doneMerge #(.WIDTH(CORES_PER_LAYER)) i_layerMerge (
      .clk    (clk),
      .rstN   (rstN),
      .clear  (strobe.clearLatches),
      .accept (strobe.acceptDone),
      .pulses (coreDone[l*CORES_PER_LAYER +: CORES_PER_LAYER]),
      .done   (layerDone[l])
    );
  end

  doneMerge #(.WIDTH(NUM_LAYERS)) i_netMerge (
    .clk    (clk),
    .rstN   (rstN),
    .clear  (strobe.clearLatches),
    .accept (strobe.acceptDone),
    .pulses (layerDone),
    .done   (netDone)
  );
endmodule

// File: rtl/tickSequencer.sv
module tickSequencer
  import tickSeqPkg::*;
#(
  parameter int NUM_LAYERS      = 3,
  parameter int CORES_PER_LAYER = 4,
  localparam int TOTAL_CORES    = NUM_LAYERS * CORES_PER_LAYER
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tickReq,
  input  logic [TOTAL_CORES-1:0] coreDone,
  output logic                   tickStart,
  output logic                   busy,
  output logic [NUM_LAYERS-1:0]  layerDone,
  output logic                   netDone
);
  seqStrobe_t strobe;

  tickCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tickReq   (tickReq),
    .netDone   (netDone),
    .tickStart (tickStart),
    .busy      (busy),
    .strobe    (strobe)
  );

  doneTree #(
    .NUM_LAYERS      (NUM_LAYERS),
    .CORES_PER_LAYER (CORES_PER_LAYER)
  ) i_tree (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .coreDone  (coreDone),
    .layerDone (layerDone),
    .netDone   (netDone)
  );
endmodule

// File: rtl/tickSequencerChecker.sv
module tickSequencerChecker #(
  parameter int NUM_LAYERS      = 3,
  parameter int CORES_PER_LAYER = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  tickStart,
  input logic                  busy,
  input logic [NUM_LAYERS-1:0] layerDone,
  input logic                  netDone
);
  a_r2_start_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    tickStart |-> !$past(busy));
  a_r2_start_one_shot: assert property (@(posedge clk) disable iff (!rstN)
    tickStart |=> !tickStart);
  a_r9_busy_with_start: assert property (@(posedge clk) disable iff (!rstN)
    tickStart |-> busy);
  a_r9_busy_falls: assert property (@(posedge clk) disable iff (!rstN)
    netDone |=> !busy);
  a_r6_net_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    netDone |-> busy);
  a_r6_net_one_shot: assert property (@(posedge clk) disable iff (!rstN)
    netDone |=> !netDone);
  a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (layerDone == '0 && !netDone));

  for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_chk
    a_r7_layer_one_shot: assert property (@(posedge clk) disable iff (!rstN)
      layerDone[g] |=> !layerDone[g]);
  end
endmodule

bind tickSequencer tickSequencerChecker #(
  .NUM_LAYERS      (NUM_LAYERS),
  .CORES_PER_LAYER (CORES_PER_LAYER)
) i_checker (
  .clk       (clk),
  .rstN      (rstN),
  .tickStart (tickStart),
  .busy      (busy),
  .layerDone (layerDone),
  .netDone   (netDone)
);

// File: tb/test_tickSequencer.sv
`timescale 1ns/1ps
module test_tickSequencer;
  localparam int NL = 3;
  localparam int NC = 4;
  localparam int NT = NL * NC;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tickReq = 1'b0;
  logic [NT-1:0] coreDone = '0;
  logic          tickStart;
  logic          busy;
  logic [NL-1:0] layerDone;
  logic          netDone;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tickSequencer #(.NUM_LAYERS(NL), .CORES_PER_LAYER(NC)) i_tickSequencer (
    .clk(clk), .rstN(rstN), .tickReq(tickReq), .coreDone(coreDone),
    .tickStart(tickStart), .busy(busy), .layerDone(layerDone), .netDone(netDone)
  );

  task automatic check(input string tag, input int actual, input int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, actual, expected, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Expected cycle of a pulse relative to tickStart cycle 0.
  function automatic int layerDueCycle(input int lastDone);
    return lastDone + 1;
  endfunction
  function automatic int netDueCycle(input int lastDone);
    return lastDone + 2;
  endfunction

  // One tick. Caller is positioned at an idle cycle, or at the tickStart
  // cycle when preStarted is set. Ends at the busy-low cycle, or at the
  // next tickStart cycle when a request was made during the tick.
  task automatic runTick(input bit preStarted, input int reqA, input int reqB,
                         input bit hold, input bit noise, input bit fixedDelays,
                         input int fixedBase);
    int d [NT];
    int maxL [NL];
    int maxAll;
    bit pend;
    if (!preStarted) begin
      tickReq = 1'b1;
      step();
      tickReq = 1'b0;
      check("R2 tickStart after idle request", tickStart, 1);
      check("R9 busy rises with tickStart", busy, 1);
    end else begin
      check("R3 held request starts tick", tickStart, 1);
    end
    maxAll = 0;
    for (int l = 0; l < NL; l++) begin
      maxL[l] = 0;
      for (int c = 0; c < NC; c++) begin
        int idx = l * NC + c;
        if (fixedDelays) d[idx] = fixedBase + (NL - 1 - l) * 3 + c;
        else             d[idx] = 1 + ($urandom % 8);
        if (d[idx] > maxL[l]) maxL[l] = d[idx];
      end
      if (maxL[l] > maxAll) maxAll = maxL[l];
    end
    pend = (reqA >= 0) || (reqB >= 0);
    for (int k = 0; k <= maxAll + 3; k++) begin
      if (k >= 1) begin
        for (int l = 0; l < NL; l++)
          check($sformatf("R5 R10 R7 layerDone[%0d] k=%0d", l, k), layerDone[l],
                (k == layerDueCycle(maxL[l])) ? 1 : 0);
        check($sformatf("R6 netDone k=%0d", k), netDone,
              (k == netDueCycle(maxAll)) ? 1 : 0);
        check($sformatf("R9 busy k=%0d", k), busy, (k <= maxAll + 2) ? 1 : 0);
        check($sformatf("R2 no extra tickStart k=%0d", k), tickStart, 0);
      end
      if (k == maxAll + 3) begin
        coreDone = '0;
        tickReq  = 1'b0;
      end else begin
        for (int i = 0; i < NT; i++)
          coreDone[i] = hold ? (k >= d[i]) : (k == d[i]);
        if (noise && k == 0) coreDone = '1;  // R8: start-cycle done ignored
        tickReq = (k == reqA) || (k == reqB);
      end
      if (k < maxAll + 3) step();
    end
    if (pend) begin
      step();
      check("R3 tickStart two cycles after netDone", tickStart, 1);
      check("R3 busy with held start", busy, 1);
    end
  endtask

  initial begin : watchdog
    for (int n = 0; n < 100000; n++) begin
      @(posedge clk);
      if (finished) disable watchdog;
    end
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    repeat (3) step();
    check("R1 tickStart in reset", tickStart, 0);
    check("R1 busy in reset", busy, 0);
    check("R1 layerDone in reset", int'(layerDone), 0);
    check("R1 netDone in reset", netDone, 0);
    rstN = 1'b1;
    step();
    check("R1 busy after reset", busy, 0);
    check("R1 tickStart after reset", tickStart, 0);

    // R8: stale done while idle must not count
    coreDone = '1;
    step();
    coreDone = '0;
    check("R8 idle done gives no layerDone", int'(layerDone), 0);
    step();
    check("R8 idle done gives no netDone", netDone, 0);

    // Directed: layers finish in reverse order, stale done in start cycle
    runTick(1'b0, -1, -1, 1'b0, 1'b1, 1'b1, 1);
    step();
    // R7: done held high to the end
    runTick(1'b0, -1, -1, 1'b1, 1'b0, 1'b0, 0);
    step();
    // R3/R4: two requests during busy merge into one follow-up tick
    runTick(1'b0, 1, 3, 1'b0, 1'b0, 1'b0, 0);
    runTick(1'b1, -1, -1, 1'b0, 1'b0, 1'b0, 0);
    for (int w = 0; w < 4; w++) begin
      step();
      check("R4 no third tick after merge", tickStart, 0);
      check("R4 stays idle", busy, 0);
    end
    // Random ticks, mixing held, noisy and pending variants
    for (int t = 0; t < 40; t++) begin
      bit h = ($urandom % 2) == 1;
      bit n = ($urandom % 2) == 1;
      bit p = ($urandom % 3) == 0;
      runTick(1'b0, p ? 2 : -1, -1, h, n, 1'b0, 0);
      if (p) runTick(1'b1, -1, -1, h, 1'b0, 1'b0, 0);
      step();
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule